// File: doc/BRIEF.md
# PCIe MSI and INTx Interrupt Aggregator

This block sits between the inbound side of a PCIe root port and the host interrupt controller. It gathers three kinds of interrupt sources: message-signalled vectors that endpoints write to a capture register, four legacy INTx level requests, and six controller error events. It presents them as one host line per MSI group, one per INTx pin and a single error line. Software sees a 32-bit register window on a simple request/write-enable bus. Each source bank has a pending-status register, an enable-set alias and an enable-clear alias. A shared acknowledge register tells the block which source has been serviced.

MSI vectors are spread over eight groups. The low three bits of a vector select the group, and the next two bits select one of four pending bits in that group. This lets one handler per group service up to four vectors. Writing the source code to the acknowledge register forces that source's host line low for at least one cycle. An edge-sensitive host controller therefore sees a fresh rising edge if the source is still active.

Top module: `irq_agg`

## Requirements
- R1: A vector V in 0..31, taken from `msi_vld_i`/`msi_vec_i` or from a bus write of V to offset 0x054, sets pending bit V>>3 of group V&7. Vectors of 32 or more change nothing.
- R2: The status register of MSI group g is at 0x104+0x10*g. A read returns the four pending bits in [3:0] with all other bits zero. Writing 1 to a bit clears it, and writing 0 leaves it.
- R3: The enable-set alias is at 0x108+0x10*g and the enable-clear alias at 0x10C+0x10*g. Ones set or clear the matching enable bits, zeros have no effect, and reading either alias returns the enable mask.
- R4: `msi_irq_o[g]` is high in the cycle after a cycle in which some bit of group g is both pending and enabled, and low otherwise.
- R5: A write of value 4+g to offset 0x050 drives `msi_irq_o[g]` low in the next cycle. The line rises again one cycle later if the group is still active. A write of value n (0..3) does the same for `intx_irq_o[n]`. Other values have no effect.
- R6: For INTx pin n, the pending flag is bit 0 of 0x184+0x10*n. It is set in every cycle `intx_i[n]` is high and is write-one-to-clear. Enable-set is at 0x188+0x10*n and enable-clear at 0x18C+0x10*n. `intx_irq_o[n]` follows pending-and-enabled as in R4.
- R7: The error status at 0x1C4 latches `err_evt_i` bits 0..5 (system, fatal, non-fatal, correctable, AXI tag lookup, ECRC) and is write-one-to-clear. Enable-set is at 0x1C8 and enable-clear at 0x1CC. `err_irq_o` follows pending-and-enabled one cycle later and ignores acknowledge writes.
- R8: When a new event and a write-one-to-clear hit the same pending bit in the same cycle, the bit stays pending.
- R9: Reads of unmapped or misaligned offsets, and of the write-only offsets 0x050 and 0x054, return zero. Writes to unmapped offsets change no state.
- R10: After reset, all pending and enable bits are zero and every output is low.
- R11: `rdata_o` carries read data in the cycle after a read request and is zero in any cycle not preceded by a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| msi_vld_i | input | 1 | Inbound MSI capture strobe |
| msi_vec_i | input | 8 | Inbound MSI vector number |
| intx_i | input | 4 | INTx level requests |
| err_evt_i | input | 6 | Error event pulses |
| msi_irq_o | output | 8 | Host line per MSI group |
| intx_irq_o | output | 4 | Host line per INTx pin |
| err_irq_o | output | 1 | Host error line |

## Verification
The hardest situation to reach is a same-cycle collision: an inbound vector and a software clear of that same pending bit. A second case is an acknowledge that lands while the source is still active, so the line must dip for exactly one cycle and come back. Directed sequences drive the inbound strobe and the clear write on the same edge, and acknowledge a group whose pending bit is left set. A seeded random phase then mixes inbound vectors, INTx level changes, error pulses, acknowledges and register accesses every cycle. This makes such overlaps frequent, and a bench model checks all three kinds of host line on every cycle.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFS_ACK       = 12'h050;
  localparam logic [AW-1:0] OFS_MSI_CAP   = 12'h054;
  localparam logic [AW-1:0] OFS_MSI_BASE  = 12'h104;
  localparam logic [AW-1:0] OFS_INTX_BASE = 12'h184;
  localparam logic [AW-1:0] OFS_ERR_BASE  = 12'h1C4;
  localparam int unsigned   BANK_STRIDE   = 16;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ESET = 2'd1,
    SEL_ECLR = 2'd2,
    SEL_NONE = 2'd3
  } bank_sel_e;

  function automatic bank_sel_e bank_decode(input logic [AW-1:0] a, input logic [AW-1:0] base);
    if (a == base)               return SEL_STAT;
    else if (a == base + 12'h4)  return SEL_ESET;
    else if (a == base + 12'h8)  return SEL_ECLR;
    else                         return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_agg_msi_dec.sv
`timescale 1ns/1ps
module irq_agg_msi_dec #(
  parameter int unsigned NUM_GRP = 8,
  parameter int unsigned GRP_W   = 4,
  localparam int unsigned TOT    = NUM_GRP * GRP_W
) (
  input  logic          a_vld_i,
  input  logic [31:0]   a_vec_i,
  input  logic          b_vld_i,
  input  logic [31:0]   b_vec_i,
  output logic [TOT-1:0] set_o
);
  // group-major layout: index g*GRP_W + b holds vector b*NUM_GRP + g
  always_comb begin
    set_o = '0;
    for (int v = 0; v < int'(TOT); v++) begin
      set_o[(v % NUM_GRP) * GRP_W + v / NUM_GRP] =
        (a_vld_i && a_vec_i == 32'(v)) || (b_vld_i && b_vec_i == 32'(v));
    end
  end
endmodule

// File: rtl/irq_agg_bank.sv
`timescale 1ns/1ps
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned   W     = 4,
  parameter logic [AW-1:0] BASE  = 12'h104,
  parameter bit            GATED = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  set_i,
  input  logic          ack_i,
  output logic [W-1:0]  pend_o,
  output logic [W-1:0]  en_o,
  output logic          irq_o,
  output logic [DW-1:0] rd_data_o
);
  bank_sel_e    sel;
  logic [W-1:0] pend_q, en_q, clr_m, es_m, ec_m;
  logic         irq_q;

  assign sel   = bank_decode(addr_i, BASE);
  assign clr_m = (wr_i && sel == SEL_STAT) ? wdata_i : '0;
  assign es_m  = (wr_i && sel == SEL_ESET) ? wdata_i : '0;
  assign ec_m  = (wr_i && sel == SEL_ECLR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_m) | set_i;  // new event beats clear
      en_q   <= (en_q | es_m) & ~ec_m;
      irq_q  <= (|(pend_q & en_q)) && !(GATED && ack_i);
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STAT:          rd_data_o = DW'(pend_q);
      SEL_ESET, SEL_ECLR: rd_data_o = DW'(en_q);
      default:           rd_data_o = '0;
    endcase
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_agg.sv
`timescale 1ns/1ps
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_GRP   = 8,
  parameter int unsigned GRP_W     = 4,
  parameter int unsigned NUM_INTX  = 4,
  parameter int unsigned ERR_W     = 6,
  parameter int unsigned MSI_VEC_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 msi_vld_i,
  input  logic [MSI_VEC_W-1:0] msi_vec_i,
  input  logic [NUM_INTX-1:0]  intx_i,
  input  logic [ERR_W-1:0]     err_evt_i,
  output logic [NUM_GRP-1:0]   msi_irq_o,
  output logic [NUM_INTX-1:0]  intx_irq_o,
  output logic                 err_irq_o
);
  localparam int unsigned TOT = NUM_GRP * GRP_W;
  localparam int unsigned NB  = NUM_GRP + NUM_INTX + 1;

  logic            wr, rd, ack_wr;
  logic [TOT-1:0]  msi_set, msi_pend, msi_en;
  logic [NUM_INTX-1:0] intx_pend, intx_en;
  logic [ERR_W-1:0] err_pend, err_en;
  logic [DW-1:0]   rd_vec [NB];
  logic [DW-1:0]   rd_or, rdata_q;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign ack_wr = wr && addr_i == OFS_ACK;

  irq_agg_msi_dec #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_msi_dec (
    .a_vld_i (msi_vld_i),
    .a_vec_i (32'(msi_vec_i)),
    .b_vld_i (wr && addr_i == OFS_MSI_CAP),
    .b_vec_i (wdata_i),
    .set_o   (msi_set)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_msi
    irq_agg_bank #(
      .W(GRP_W), .BASE(OFS_MSI_BASE + AW'(g * BANK_STRIDE)), .GATED(1'b1)
    ) u_bank (
      .clk_i, .rst_ni,
      .wr_i      (wr),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i[GRP_W-1:0]),
      .set_i     (msi_set[g*GRP_W +: GRP_W]),
      .ack_i     (ack_wr && wdata_i == 32'(NUM_INTX + g)),
      .pend_o    (msi_pend[g*GRP_W +: GRP_W]),
      .en_o      (msi_en[g*GRP_W +: GRP_W]),
      .irq_o     (msi_irq_o[g]),
      .rd_data_o (rd_vec[g])
    );
  end

  for (genvar n = 0; n < NUM_INTX; n++) begin : g_intx
    irq_agg_bank #(
      .W(1), .BASE(OFS_INTX_BASE + AW'(n * BANK_STRIDE)), .GATED(1'b1)
    ) u_bank (
      .clk_i, .rst_ni,
      .wr_i      (wr),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i[0]),
      .set_i     (intx_i[n]),
      .ack_i     (ack_wr && wdata_i == 32'(n)),
      .pend_o    (intx_pend[n]),
      .en_o      (intx_en[n]),
      .irq_o     (intx_irq_o[n]),
      .rd_data_o (rd_vec[NUM_GRP+n])
    );
  end

  irq_agg_bank #(.W(ERR_W), .BASE(OFS_ERR_BASE), .GATED(1'b0)) u_err (
    .clk_i, .rst_ni,
    .wr_i      (wr),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i[ERR_W-1:0]),
    .set_i     (err_evt_i),
    .ack_i     (1'b0),
    .pend_o    (err_pend),
    .en_o      (err_en),
    .irq_o     (err_irq_o),
    .rd_data_o (rd_vec[NB-1])
  );

  always_comb begin
    rd_or = '0;
    for (int i = 0; i < int'(NB); i++) rd_or |= rd_vec[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd ? rd_or : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_agg_chk.sv
`timescale 1ns/1ps
module irq_agg_chk #(
  parameter int unsigned NUM_GRP   = 8,
  parameter int unsigned GRP_W     = 4,
  parameter int unsigned NUM_INTX  = 4,
  parameter int unsigned ERR_W     = 6,
  parameter int unsigned MSI_VEC_W = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [11:0]                addr_i,
  input logic [31:0]                wdata_i,
  input logic [31:0]                rdata_o,
  input logic                       msi_vld_i,
  input logic [MSI_VEC_W-1:0]       msi_vec_i,
  input logic [NUM_INTX-1:0]        intx_i,
  input logic [NUM_GRP-1:0]         msi_irq_o,
  input logic [NUM_INTX-1:0]        intx_irq_o,
  input logic                       err_irq_o,
  input logic [NUM_GRP*GRP_W-1:0]   msi_pend,
  input logic [NUM_GRP*GRP_W-1:0]   msi_en,
  input logic [NUM_INTX-1:0]        intx_pend,
  input logic [ERR_W-1:0]           err_pend,
  input logic [ERR_W-1:0]           err_en
);
  logic ack_wr;
  assign ack_wr = req_i && we_i && addr_i == 12'h050;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    p_line_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msi_irq_o[g] |-> $past(|(msi_pend[g*GRP_W +: GRP_W] & msi_en[g*GRP_W +: GRP_W])));
    p_ack_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_wr && wdata_i == 32'(NUM_INTX + g)) |=> !msi_irq_o[g]);
    for (genvar b = 0; b < GRP_W; b++) begin : g_bit
      p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msi_vld_i && 32'(msi_vec_i) == 32'(b * NUM_GRP + g)) |=> msi_pend[g*GRP_W + b]);
    end
  end

  for (genvar n = 0; n < NUM_INTX; n++) begin : g_intx
    p_intx_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_wr && wdata_i == 32'(n)) |=> !intx_irq_o[n]);
    p_intx_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      intx_i[n] |=> intx_pend[n]);
  end

  p_err_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> $past(|(err_pend & err_en)));
  p_unmapped_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i >= 12'h200) |=> rdata_o == 32'h0);
  p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == 32'h0);
endmodule

bind irq_agg irq_agg_chk #(
  .NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .NUM_INTX(NUM_INTX), .ERR_W(ERR_W), .MSI_VEC_W(MSI_VEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .msi_vld_i(msi_vld_i), .msi_vec_i(msi_vec_i),
  .intx_i(intx_i), .msi_irq_o(msi_irq_o), .intx_irq_o(intx_irq_o), .err_irq_o(err_irq_o),
  .msi_pend(msi_pend), .msi_en(msi_en), .intx_pend(intx_pend),
  .err_pend(err_pend), .err_en(err_en)
);

// File: tb/irq_agg_tb.sv
`timescale 1ns/1ps
module irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        msi_vld = 1'b0;
  logic [7:0]  msi_vec = '0;
  logic [3:0]  intx = '0;
  logic [5:0]  err_evt = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;
  logic        err_irq;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .msi_vld_i(msi_vld), .msi_vec_i(msi_vec),
    .intx_i(intx), .err_evt_i(err_evt), .msi_irq_o(msi_irq),
    .intx_irq_o(intx_irq), .err_irq_o(err_irq)
  );

  // reference model built from the requirements
  logic [7:0][3:0] m_pend, m_en;
  logic [7:0]      m_mirq;
  logic [3:0]      m_ip, m_ie, m_iirq;
  logic [5:0]      m_ep, m_ee;
  logic            m_eirq;

  always @(posedge clk or negedge rst_n) begin : model
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_mirq <= '0;
      m_ip <= '0; m_ie <= '0; m_iirq <= '0;
      m_ep <= '0; m_ee <= '0; m_eirq <= 1'b0;
    end else begin
      for (int g = 0; g < 8; g++) begin
        for (int b = 0; b < 4; b++) begin
          if ((msi_vld && 32'(msi_vec) == 32'(b*8+g)) ||
              (req && we && addr == 12'h054 && wdata == 32'(b*8+g)))
            m_pend[g][b] <= 1'b1;
          else if (req && we && addr == 12'h104 + 12'(16*g) && wdata[b])
            m_pend[g][b] <= 1'b0;
        end
        if (req && we && addr == 12'h108 + 12'(16*g)) m_en[g] <= m_en[g] | wdata[3:0];
        if (req && we && addr == 12'h10C + 12'(16*g)) m_en[g] <= m_en[g] & ~wdata[3:0];
        m_mirq[g] <= (|(m_pend[g] & m_en[g])) &&
                     !(req && we && addr == 12'h050 && wdata == 32'(4+g));
      end
      for (int n = 0; n < 4; n++) begin
        if (intx[n]) m_ip[n] <= 1'b1;
        else if (req && we && addr == 12'h184 + 12'(16*n) && wdata[0]) m_ip[n] <= 1'b0;
        if (req && we && addr == 12'h188 + 12'(16*n) && wdata[0]) m_ie[n] <= 1'b1;
        if (req && we && addr == 12'h18C + 12'(16*n) && wdata[0]) m_ie[n] <= 1'b0;
        m_iirq[n] <= (m_ip[n] && m_ie[n]) &&
                     !(req && we && addr == 12'h050 && wdata == 32'(n));
      end
      for (int e = 0; e < 6; e++) begin
        if (err_evt[e]) m_ep[e] <= 1'b1;
        else if (req && we && addr == 12'h1C4 && wdata[e]) m_ep[e] <= 1'b0;
      end
      if (req && we && addr == 12'h1C8) m_ee <= m_ee | wdata[5:0];
      if (req && we && addr == 12'h1CC) m_ee <= m_ee & ~wdata[5:0];
      m_eirq <= |(m_ep & m_ee);
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    for (int g = 0; g < 8; g++) begin
      if (a == 12'h104 + 12'(16*g)) return 32'(m_pend[g]);
      if (a == 12'h108 + 12'(16*g) || a == 12'h10C + 12'(16*g)) return 32'(m_en[g]);
    end
    for (int n = 0; n < 4; n++) begin
      if (a == 12'h184 + 12'(16*n)) return 32'(m_ip[n]);
      if (a == 12'h188 + 12'(16*n) || a == 12'h18C + 12'(16*n)) return 32'(m_ie[n]);
    end
    if (a == 12'h1C4) return 32'(m_ep);
    if (a == 12'h1C8 || a == 12'h1CC) return 32'(m_ee);
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      chk(msi_irq == m_mirq, "R4 msi lines", 32'(msi_irq), 32'(m_mirq));
      chk(intx_irq == m_iirq, "R6 intx lines", 32'(intx_irq), 32'(m_iirq));
      chk(err_irq == m_eirq, "R7 error line", 32'(err_irq), 32'(m_eirq));
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic msi_pulse(input logic [7:0] v);
    @(negedge clk); msi_vld = 1'b1; msi_vec = v;
    @(negedge clk); msi_vld = 1'b0;
  endtask

  initial begin : watchdog
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd_exp;
    bit rd_pend;
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(msi_irq == 8'h0 && intx_irq == 4'h0 && !err_irq, "R10 outputs after reset",
        {19'h0, err_irq, intx_irq, msi_irq}, 32'h0);
    chk(rdata == 32'h0, "R10 rdata after reset", rdata, 32'h0);
    mon_on = 1'b1;
    bus_rd(12'h108, 32'h0, "R10 enable after reset");
    bus_rd(12'h1C4, 32'h0, "R10 error status after reset");

    // R1 capture paths
    msi_pulse(8'd13);
    bus_rd(12'h154, 32'h2, "R1 inbound vector 13 -> group5 bit1");
    bus_wr(12'h054, 32'd6);
    bus_rd(12'h164, 32'h1, "R1 bus capture vector 6 -> group6 bit0");
    msi_pulse(8'd40);
    bus_rd(12'h104, 32'h0, "R1 vector 40 ignored");
    bus_wr(12'h054, 32'd32);
    bus_rd(12'h104, 32'h0, "R1 bus vector 32 ignored");

    // R3 enable aliases
    bus_wr(12'h158, 32'hF);
    bus_rd(12'h15C, 32'hF, "R3 enable read via clear alias");
    bus_wr(12'h15C, 32'h1);
    bus_rd(12'h158, 32'hE, "R3 enable clear bit0");
    bus_wr(12'h158, 32'h0);
    bus_rd(12'h158, 32'hE, "R3 zero write no effect");

    // R4 line high
    chk(msi_irq == 8'h20, "R4 group5 line only", 32'(msi_irq), 32'h20);

    // R5 acknowledge
    bus_wr(12'h050, 32'd9);
    chk(msi_irq[5] == 1'b0, "R5 group5 drops after ack", 32'(msi_irq[5]), 32'h0);
    @(negedge clk);
    chk(msi_irq[5] == 1'b1, "R5 group5 rises again", 32'(msi_irq[5]), 32'h1);
    bus_wr(12'h050, 32'd20);
    chk(msi_irq[5] == 1'b1, "R5 unused ack code no effect", 32'(msi_irq[5]), 32'h1);

    // R2 write-one-to-clear
    bus_wr(12'h154, 32'hFFFF_FFFD);
    bus_rd(12'h154, 32'h2, "R2 zero bit keeps pending");
    bus_wr(12'h154, 32'h2);
    bus_rd(12'h154, 32'h0, "R2 clear group5 bit1");
    chk(msi_irq[5] == 1'b0, "R2 group5 line low after clear", 32'(msi_irq[5]), 32'h0);

    // R8 set and clear in the same cycle
    @(negedge clk);
    msi_vld = 1'b1; msi_vec = 8'd9; req = 1'b1; we = 1'b1; addr = 12'h114; wdata = 32'h2;
    @(negedge clk);
    msi_vld = 1'b0; req = 1'b0; we = 1'b0;
    bus_rd(12'h114, 32'h2, "R8 set beats clear");

    // R6 INTx
    @(negedge clk); intx = 4'b0100;
    bus_wr(12'h1A8, 32'h1);
    @(negedge clk);
    chk(intx_irq == 4'b0100, "R6 intx2 line", 32'(intx_irq), 32'h4);
    bus_wr(12'h1A4, 32'h1);
    bus_rd(12'h1A4, 32'h1, "R6 level re-sets pending");
    bus_wr(12'h050, 32'd2);
    chk(intx_irq[2] == 1'b0, "R5 intx2 drops after ack", 32'(intx_irq[2]), 32'h0);
    intx = 4'b0000;
    bus_wr(12'h1A4, 32'h1);
    bus_rd(12'h1A4, 32'h0, "R6 clear after level drop");
    bus_wr(12'h1AC, 32'h1);
    bus_rd(12'h1A8, 32'h0, "R6 enable clear");

    // R7 error
    @(negedge clk); err_evt = 6'h10;
    @(negedge clk); err_evt = 6'h0;
    bus_rd(12'h1C4, 32'h10, "R7 AXI tag error latched in bit4");
    bus_wr(12'h1C8, 32'h3F);
    @(negedge clk);
    chk(err_irq == 1'b1, "R7 error line high", 32'(err_irq), 32'h1);
    bus_wr(12'h050, 32'd4);
    chk(err_irq == 1'b1, "R7 ack does not gate error line", 32'(err_irq), 32'h1);
    bus_wr(12'h1C4, 32'h10);
    bus_rd(12'h1C4, 32'h0, "R7 error cleared");
    chk(err_irq == 1'b0, "R7 error line low", 32'(err_irq), 32'h0);

    // R9 unmapped, R11 idle
    bus_wr(12'h300, 32'hFFFF_FFFF);
    bus_rd(12'h300, 32'h0, "R9 unmapped read zero");
    bus_rd(12'h054, 32'h0, "R9 capture offset reads zero");
    bus_rd(12'h050, 32'h0, "R9 ack offset reads zero");
    bus_rd(12'h106, 32'h0, "R9 misaligned read zero");
    bus_wr(12'h100, 32'hF);
    bus_rd(12'h108, 32'h0, "R9 unmapped write no effect");
    @(negedge clk);
    chk(rdata == 32'h0, "R11 rdata zero when idle", rdata, 32'h0);

    // random phase
    rd_pend = 1'b0;
    rd_exp = '0;
    for (int i = 0; i < 4000; i++) begin
      int unsigned op, bank, rsel;
      @(negedge clk);
      if (rd_pend) chk(rdata == rd_exp, "R11 random read data", rdata, rd_exp);
      rd_pend = 1'b0;
      msi_vld = ($urandom % 4) == 0;
      msi_vec = 8'($urandom % 40);
      for (int n = 0; n < 4; n++) if (($urandom % 16) == 0) intx[n] = ~intx[n];
      err_evt = (($urandom % 8) == 0) ? 6'(1 << ($urandom % 6)) : 6'h0;
      op   = $urandom % 10;
      bank = $urandom % 13;
      rsel = $urandom % 4;
      req = 1'b0; we = 1'b0;
      if (bank < 8)       addr = 12'h104 + 12'(16*bank) + 12'(4*rsel);
      else if (bank < 12) addr = 12'h184 + 12'(16*(bank-8)) + 12'(4*rsel);
      else                addr = 12'h1C4 + 12'(4*rsel);
      if (op < 4) begin
        if (($urandom % 4) == 0) addr = 12'($urandom);
        req = 1'b1;
        rd_exp = exp_rd(addr);
        rd_pend = 1'b1;
      end else if (op < 8) begin
        req = 1'b1; we = 1'b1;
        wdata = (rsel == 0) ? ($urandom & $urandom) : $urandom;
      end else if (op == 8) begin
        req = 1'b1; we = 1'b1; addr = 12'h050; wdata = $urandom % 16;
      end else if (($urandom % 2) == 0) begin
        req = 1'b1; we = 1'b1; addr = 12'h054; wdata = $urandom % 40;
      end
    end
    @(negedge clk);
    if (rd_pend) chk(rdata == rd_exp, "R11 random read data", rdata, rd_exp);
    req = 1'b0; we = 1'b0; msi_vld = 1'b0; err_evt = '0;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule